// File: doc/BRIEF.md
# Cascaded Delay Stage Controller

This block turns one wide delay request into settings for a chain of latched programmable delay stages. Each stage has a 10-bit step code, a latch enable and two overrides: one forces the stage to its shortest setting and the other forces it to its longest. The first stage, called the lead stage, is programmed directly from the low code bits of the request. Every later stage, called a follower, is steered by one request bit of its own. That bit forces the follower to its minimum or to its maximum, so the chain needs no glue logic outside this block.

A load strobe captures the request. On the next clock edge the block updates every stage setting and opens all latch enables together for exactly one cycle, then closes them again. At the same edge it also presents the total end-to-end delay expected from the chain, counted in steps. The total includes one fixed latency per stage, so a deskew loop can compare it with a measured delay.

Top module: `dly_cascade_ctrl`

## Requirements
- R1: After reset, every stage code is zero and every latch enable is high. The lead stage has both overrides low. Each follower has its minimum override high and its maximum override low. The total equals N_STAGES × FIXED_STEPS.
- R2: On a load, the lead stage code (bits [9:0] of `stage_code_o`) takes request bits [9:0], and the lead stage's overrides stay low.
- R3: On a load with the follower bit low, follower k has its minimum override high, its maximum override low and its code at zero. The follower bit for follower k (k ≥ 1) is request bit 10+k−1.
- R4: On a load with the follower bit high, follower k has its minimum override low, its maximum override high and its code at zero.
- R5: The total equals N_STAGES × FIXED_STEPS, plus the lead code, plus 1024 for each follower bit that is set. It changes at the same edge as the stage settings.
- R6: In the cycle after a load edge, all latch enables are low together. They return high after the first edge that sees no load. Stage settings change only while the enables are low.
- R7: Without a load, changes on the request input have no effect on any output.
- R8: No stage ever has both overrides high, and the lead stage never has either override high.
- R9: An all-ones request gives the largest total: 1023 + 1024 × (N_STAGES−1) + N_STAGES × FIXED_STEPS. This is 3791 with the default parameters.
- R10: With loads on consecutive cycles, the enables stay low throughout, and the settings of the last captured request are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe; captures `req_i` |
| req_i | input | CODE_W+N_STAGES−1 | Wide delay request: lead code in the low bits, one follower bit per added stage above it |
| stage_code_o | output | N_STAGES×CODE_W | Step code of each stage; stage k at bits [k×CODE_W +: CODE_W] |
| stage_len_o | output | N_STAGES | Latch enable per stage; low opens the latch, high holds |
| stage_min_o | output | N_STAGES | Force-minimum override per stage |
| stage_max_o | output | N_STAGES | Force-maximum override per stage |
| total_o | output | TOT_W | Expected total delay in steps, including all fixed latencies |

## Verification
The bench targets the all-ones request, the all-zero request, requests that set only the follower bits, and back-to-back loads. A design that weighted follower bits in binary, or skipped the extra step that the maximum override adds, would report a wrong total at the extremes. Flipping the minimum/maximum mapping would set the wrong override on followers. The bench also changes the request without a load, to catch a design that leaks request bits straight through to the outputs. It runs back-to-back loads as well, which would show up a sequencer that closes the latches while a newer request is still being applied.

// File: rtl/dlychain_pkg.sv
`timescale 1ns/1ps
package dlychain_pkg;

  // Latch sequencer state: HOLD keeps every stage latch closed.
  typedef enum logic {
    LATCH_OPEN = 1'b0,
    LATCH_HOLD = 1'b1
  } latch_st_t;

  // Override pair of one stage.
  typedef struct packed {
    logic force_min;
    logic force_max;
  } ovr_t;

  localparam ovr_t OVR_NONE = '{force_min: 1'b0, force_max: 1'b0};
  localparam ovr_t OVR_MIN  = '{force_min: 1'b1, force_max: 1'b0};
  localparam ovr_t OVR_MAX  = '{force_min: 1'b0, force_max: 1'b1};

endpackage

// File: rtl/dly_lead_cfg.sv
`timescale 1ns/1ps
module dly_lead_cfg
  import dlychain_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int FIXED_STEPS = 240,
  parameter int DLY_W       = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_req_i,
  output logic [CODE_W-1:0] code_o,
  output ovr_t              ovr_o,
  output logic [DLY_W-1:0]  dly_next_o
);

  // Delay this stage will have once the pending request is applied.
  always_comb begin
    dly_next_o = DLY_W'(FIXED_STEPS) + DLY_W'(code_req_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      ovr_o  <= OVR_NONE;
    end else if (load_i) begin
      code_o <= code_req_i;
      ovr_o  <= OVR_NONE;
    end
  end

  // R2: the lead code follows the request on a load
  p_lead_track_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (code_o == $past(code_req_i)));

  // R8: the lead stage is never overridden
  p_lead_free_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_o == OVR_NONE);

  // R7: no load, no change
  p_lead_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(code_o));

endmodule

// File: rtl/dly_follow_cfg.sv
`timescale 1ns/1ps
module dly_follow_cfg
  import dlychain_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int FIXED_STEPS = 240,
  parameter int DLY_W       = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              casc_i,
  output logic [CODE_W-1:0] code_o,
  output ovr_t              ovr_o,
  output logic [DLY_W-1:0]  dly_next_o
);

  localparam int FULL_SPAN = 2 ** CODE_W;

  ovr_t ovr_next;

  // A follower is either pinned low or pinned high; its code latches sit at zero.
  always_comb begin
    ovr_next   = casc_i ? OVR_MAX : OVR_MIN;
    dly_next_o = DLY_W'(FIXED_STEPS) + (casc_i ? DLY_W'(FULL_SPAN) : '0);
  end

  assign code_o = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_o <= OVR_MIN;
    end else if (load_i) begin
      ovr_o <= ovr_next;
    end
  end

  // R3: low follower bit pins the stage at its minimum
  p_follow_min_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && !casc_i) |=> (ovr_o.force_min && !ovr_o.force_max));

  // R4: high follower bit pins the stage at its maximum
  p_follow_max_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && casc_i) |=> (!ovr_o.force_min && ovr_o.force_max));

  // R8: exactly one override active on a follower
  p_follow_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(ovr_o) == 1);

  // R7: overrides hold without a load
  p_follow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(ovr_o));

endmodule

// File: rtl/dly_latch_seq.sv
`timescale 1ns/1ps
module dly_latch_seq
  import dlychain_pkg::*;
#(
  parameter int N_STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  output logic [N_STAGES-1:0] len_o
);

  latch_st_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LATCH_HOLD;
    end else begin
      st_q <= load_i ? LATCH_OPEN : LATCH_HOLD;
    end
  end

  // One registered enable per stage, all driven from the same state.
  for (genvar k = 0; k < N_STAGES; k++) begin : g_len
    always_ff @(posedge clk) begin
      if (rst) begin
        len_o[k] <= 1'b1;
      end else begin
        len_o[k] <= (load_i ? LATCH_OPEN : LATCH_HOLD) == LATCH_HOLD;
      end
    end
  end

  // R6: enables move together
  p_len_together_r6: assert property (@(posedge clk) disable iff (rst)
    (len_o == '0) || (len_o == '1));

  // R6: enables follow the sequencer state
  p_len_state_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == LATCH_OPEN) == (len_o == '0));

  // R10: a load keeps the window open for the following cycle
  p_len_open_r10: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (len_o == '0));

endmodule

// File: rtl/dly_total_sum.sv
`timescale 1ns/1ps
module dly_total_sum #(
  parameter int N_STAGES  = 3,
  parameter int DLY_W     = 11,
  parameter int TOT_W     = 12,
  parameter int RST_TOTAL = 720,
  parameter int MAX_TOTAL = 3791
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load_i,
  input  logic [N_STAGES-1:0][DLY_W-1:0] dly_next_i,
  output logic [TOT_W-1:0]               total_o
);

  logic [TOT_W-1:0] sum_next;

  always_comb begin
    sum_next = '0;
    for (int k = 0; k < N_STAGES; k++) begin
      sum_next = sum_next + TOT_W'(dly_next_i[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      total_o <= TOT_W'(RST_TOTAL);
    end else if (load_i) begin
      total_o <= sum_next;
    end
  end

  // R5: the total never drops below the fixed latency floor
  p_total_floor_r5: assert property (@(posedge clk) disable iff (rst)
    int'(total_o) >= RST_TOTAL);

  // R9: the total never exceeds the all-ones request
  p_total_ceiling_r9: assert property (@(posedge clk) disable iff (rst)
    int'(total_o) <= MAX_TOTAL);

  // R7: total holds without a load
  p_total_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(total_o));

endmodule

// File: rtl/dly_cascade_ctrl.sv
`timescale 1ns/1ps
module dly_cascade_ctrl
  import dlychain_pkg::*;
#(
  parameter int N_STAGES    = 3,
  parameter int CODE_W      = 10,
  parameter int FIXED_STEPS = 240,
  localparam int REQ_W      = CODE_W + N_STAGES - 1,
  localparam int FULL_SPAN  = 2 ** CODE_W,
  localparam int RST_TOTAL  = N_STAGES * FIXED_STEPS,
  localparam int MAX_TOTAL  = RST_TOTAL + (FULL_SPAN - 1) + (N_STAGES - 1) * FULL_SPAN,
  localparam int TOT_W      = $clog2(MAX_TOTAL + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic [REQ_W-1:0]           req_i,
  output logic [N_STAGES*CODE_W-1:0] stage_code_o,
  output logic [N_STAGES-1:0]        stage_len_o,
  output logic [N_STAGES-1:0]        stage_min_o,
  output logic [N_STAGES-1:0]        stage_max_o,
  output logic [TOT_W-1:0]           total_o
);

  localparam int DLY_W = $clog2(FIXED_STEPS + FULL_SPAN + 1);

  logic [N_STAGES-1:0][DLY_W-1:0] dly_next;
  ovr_t [N_STAGES-1:0]            ovr;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_lead
      dly_lead_cfg #(
        .CODE_W     (CODE_W),
        .FIXED_STEPS(FIXED_STEPS),
        .DLY_W      (DLY_W)
      ) u_lead (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .code_req_i(req_i[CODE_W-1:0]),
        .code_o    (stage_code_o[k*CODE_W +: CODE_W]),
        .ovr_o     (ovr[k]),
        .dly_next_o(dly_next[k])
      );
    end else begin : g_follow
      dly_follow_cfg #(
        .CODE_W     (CODE_W),
        .FIXED_STEPS(FIXED_STEPS),
        .DLY_W      (DLY_W)
      ) u_follow (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .casc_i    (req_i[CODE_W+k-1]),
        .code_o    (stage_code_o[k*CODE_W +: CODE_W]),
        .ovr_o     (ovr[k]),
        .dly_next_o(dly_next[k])
      );
    end
    assign stage_min_o[k] = ovr[k].force_min;
    assign stage_max_o[k] = ovr[k].force_max;
  end

  dly_latch_seq #(
    .N_STAGES(N_STAGES)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .load_i(load_i),
    .len_o (stage_len_o)
  );

  dly_total_sum #(
    .N_STAGES (N_STAGES),
    .DLY_W    (DLY_W),
    .TOT_W    (TOT_W),
    .RST_TOTAL(RST_TOTAL),
    .MAX_TOTAL(MAX_TOTAL)
  ) u_sum (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_i),
    .dly_next_i(dly_next),
    .total_o   (total_o)
  );

  // R5: reported total agrees with the settings actually presented
  p_total_match_r5: assert property (@(posedge clk) disable iff (rst)
    int'(total_o) == RST_TOTAL + int'(stage_code_o[CODE_W-1:0])
                     + $countones(stage_max_o) * FULL_SPAN);

  // R6: settings only move while the latch window is open
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !($stable(stage_code_o) && $stable(stage_min_o) && $stable(stage_max_o))
      |-> (stage_len_o == '0));

endmodule

// File: tb/dly_cascade_ctrl_test.sv
`timescale 1ns/1ps
module dly_cascade_ctrl_test;

  localparam int N  = 3;
  localparam int CW = 10;
  localparam int FX = 240;
  localparam int RW = CW + N - 1;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [RW-1:0] req = '0;
  logic [N*CW-1:0] code;
  logic [N-1:0] len, smin, smax;
  logic [TW-1:0] total;

  int checks = 0;
  int errors = 0;
  logic [RW-1:0] model_req = '0;

  dly_cascade_ctrl #(.N_STAGES(N), .CODE_W(CW), .FIXED_STEPS(FX)) uut (
    .clk(clk), .rst(rst), .load_i(load), .req_i(req),
    .stage_code_o(code), .stage_len_o(len), .stage_min_o(smin),
    .stage_max_o(smax), .total_o(total)
  );

  always #4 clk = ~clk;

  function automatic int exp_total(logic [RW-1:0] r);
    int t = N * FX + int'(r[CW-1:0]);
    for (int k = 1; k < N; k++) if (r[CW+k-1]) t += (1 << CW);
    return t;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(int exp_open);
    chk("R6 latch enables", int'(len), exp_open ? 0 : (1 << N) - 1);
    chk("R2 lead code", int'(code[CW-1:0]), int'(model_req[CW-1:0]));
    chk("R8 lead overrides", int'({smin[0], smax[0]}), 0);
    for (int k = 1; k < N; k++) begin
      if (model_req[CW+k-1]) begin
        chk("R4 follower min", int'(smin[k]), 0);
        chk("R4 follower max", int'(smax[k]), 1);
      end else begin
        chk("R3 follower min", int'(smin[k]), 1);
        chk("R3 follower max", int'(smax[k]), 0);
      end
      chk("R3 follower code", int'(code[k*CW +: CW]), 0);
      chk("R8 exclusive overrides", int'(smin[k] & smax[k]), 0);
    end
    chk("R5 total", int'(total), exp_total(model_req));
  endtask

  task automatic do_load(logic [RW-1:0] r);
    @(negedge clk); req = r; load = 1'b1;
    @(negedge clk); load = 1'b0; model_req = r;
    check_state(1);
    @(negedge clk);
    check_state(0);
  endtask

  task automatic poke(logic [RW-1:0] r);
    @(negedge clk); req = r; load = 1'b0;
    @(negedge clk);
    chk("R7 total unaffected", int'(total), exp_total(model_req));
    check_state(0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset total", int'(total), N * FX);
    chk("R1 reset codes", int'(code), 0);
    check_state(0);

    // directed corners
    do_load('0);
    do_load({{(N-1){1'b0}}, {CW{1'b1}}});
    do_load({{(N-1){1'b1}}, {CW{1'b0}}});
    do_load('1);
    chk("R9 max total", int'(total), (1 << CW) - 1 + (N - 1) * (1 << CW) + N * FX);
    poke('0);
    poke(RW'(12'h5A5));

    // R10 back-to-back loads
    @(negedge clk); req = RW'(12'h123); load = 1'b1;
    @(negedge clk); req = RW'(12'h8FE); model_req = RW'(12'h123);
    check_state(1);
    @(negedge clk); load = 1'b0; model_req = RW'(12'h8FE);
    chk("R10 last request applied", int'(total), exp_total(RW'(12'h8FE)));
    check_state(1);
    @(negedge clk);
    check_state(0);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [RW-1:0] r;
      r = RW'($urandom);
      if ($urandom_range(0, 3) != 0) do_load(r);
      else poke(r);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule